// File: doc/BRIEF.md
# Shadowed Up/Down PWM Timer

This block is a 16-bit timer that serves as a time base for compare and PWM logic. A counter runs against a period value and a compare value. Software writes both values through a small register port. Each write lands in a shadow copy, and the shadow moves into the active copy only at a defined point in the count cycle. A new period or pulse width therefore always takes effect on a cycle boundary and never in the middle of one.

The count clock comes from the system clock or from a synchronised external input. A power-of-two prescaler divides the chosen clock. The control register selects one of three running modes: a sawtooth that counts up and wraps, a triangle that counts up and down, and a mode in which an external pin sets the direction. Four events (zero reached, all-ones reached, compare match, period match) set sticky flags. Software clears a flag by writing 1 to it. A single interrupt line is the OR of the flags that are set and enabled. The PWM output is high while the timer runs and the count is at or above the active compare value.

Top module: `gp_pwm_timer`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7), the flags, `irq_o` and `pwm_o` are zero.
- R2: A write to address 2 (period) or 3 (compare) updates only the shadow copy, which reads back at address 6 (period) or 7 (compare). The active copy reads back at address 2 or 3. The active period loads from its shadow on the step at which the counter reaches 0.
- R3: Control bit 6 selects when the compare value reloads. When it is 0, the active compare loads on the step at which the counter reaches 0. When it is 1, it also loads on the step at which the counter reaches the active period.
- R4: Mode 1 (control bits 1:0 = 1) counts up by one per step and goes from the active period to 0 on the next step.
- R5: Mode 2 counts up to the active period, then down to 0, then up again. A control write restarts the direction as up.
- R6: In mode 3, `dir_i` high counts up and wraps from the period to 0, and `dir_i` low counts down and wraps from 0 to the period. `dir_i` passes through a two-stage synchroniser.
- R7: In mode 0 the counter holds its value.
- R8: Control bits 4:2 hold n. The counter makes one step per 2^n source pulses, and any control write restarts the prescaler.
- R9: Control bit 5 selects the source. When it is 0, every system clock is a pulse. When it is 1, each rising edge of `ext_clk_i` is a pulse, seen after a two-stage synchroniser. With no edges, the counter does not move.
- R10: A step that brings the counter to 0 sets flag bit 0. Reaching 16'hFFFF sets bit 1, reaching the active compare sets bit 2, and reaching the active period sets bit 3. Flags read at address 5 and on `flags_o`. They stay set until 1 is written to their bit at address 5, and a new event in the same cycle wins over the clear.
- R11: `irq_o` is the OR of the flags ANDed with the enable bits at address 4, bits 3:0.
- R12: `pwm_o` is high when the mode is not 0 and the counter is greater than or equal to the active compare.
- R13: A write to address 1 loads the counter at once. It overrides a step in the same cycle and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| ext_clk_i | input | 1 | External count clock |
| dir_i | input | 1 | Direction input for mode 3 (1 = up) |
| flags_o | output | 4 | Sticky event flags |
| irq_o | output | 1 | Interrupt request |
| pwm_o | output | 1 | Compare/PWM output |

## Verification
A wrong direction bit or a wrong wrap decision shows up on the count readback at the next step, and `pwm_o` shows it once the count crosses the compare value. A shadow that loads too early or too late shows up at address 2 or 3 on the exact step where it loaded, so the bench watches the active copies cycle by cycle around zero and period crossings. Prescaler or synchroniser faults shift each step by whole clocks, and the bench counts these edge for edge. A flag that is set wrongly or lost appears on `flags_o` at once and on `irq_o` as soon as that flag is enabled.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int NUM_EV = 4;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_DIR  = 2'd3
  } mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRD    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd4;
  localparam logic [ADDR_W-1:0] A_IFLG   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PRD_SH = 3'd6;
  localparam logic [ADDR_W-1:0] A_CMP_SH = 3'd7;

  localparam int EV_ZERO = 0;
  localparam int EV_OVF  = 1;
  localparam int EV_CMP  = 2;
  localparam int EV_PRD  = 3;

  localparam int CB_PS_LO  = 2;
  localparam int CB_EXT    = 5;
  localparam int CB_DBLUPD = 6;
endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ext_sel,
  input  logic            ext_clk_i,
  input  logic [PS_W-1:0] presc_n,
  input  logic            restart,
  output logic            tick_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [2:0]      ext_sync_q;
  logic [PC_W-1:0] pcnt_q, pcnt_d, mask;
  logic            pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync_q <= '0;
    else        ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};
  end

  always_comb begin
    pulse  = run && (ext_sel ? (ext_sync_q[1] && !ext_sync_q[2]) : 1'b1);
    mask   = ~({PC_W{1'b1}} << presc_n);
    tick_o = pulse && ((pcnt_q & mask) == mask);
    pcnt_d = pcnt_q;
    if (restart)    pcnt_d = '0;
    else if (pulse) pcnt_d = pcnt_q + {{(PC_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/gpt_shadow_reg.sv
module gpt_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] sh_d, act_d;

  always_comb begin
    sh_d  = wr_en ? wr_data : shadow_o;
    act_d = load ? shadow_o : active_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_o <= '0;
      active_o <= '0;
    end else begin
      shadow_o <= sh_d;
      active_o <= act_d;
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_e             mode,
  input  logic              dir_i,
  input  logic              dir_restart,
  input  logic [W-1:0]      prd,
  input  logic [W-1:0]      cmp,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wr_data,
  output logic [W-1:0]      cnt_o,
  output logic [NUM_EV-1:0] ev_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [1:0]   dir_sync_q;
  logic         up_q, up_d;
  logic [W-1:0] nxt, cnt_d;
  logic         step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_sync_q <= '0;
    else        dir_sync_q <= {dir_sync_q[0], dir_i};
  end

  always_comb begin
    nxt  = cnt_o;
    up_d = up_q;
    unique case (mode)
      MODE_UP:   nxt = (cnt_o >= prd) ? '0 : cnt_o + ONE;
      MODE_UPDN: begin
        if (up_q && cnt_o < prd) nxt = cnt_o + ONE;
        else if (cnt_o != '0)    nxt = cnt_o - ONE;
        up_d = (nxt == '0) ? 1'b1 : ((nxt >= prd) ? 1'b0 : up_q);
      end
      MODE_DIR: begin
        if (dir_sync_q[1]) nxt = (cnt_o >= prd) ? '0 : cnt_o + ONE;
        else               nxt = (cnt_o == '0) ? prd : cnt_o - ONE;
      end
      default: nxt = cnt_o;
    endcase
    step  = tick && !cnt_wr;
    cnt_d = cnt_wr ? cnt_wr_data : (step ? nxt : cnt_o);
    ev_o[EV_ZERO] = step && (nxt == '0);
    ev_o[EV_OVF]  = step && (nxt == '1);
    ev_o[EV_CMP]  = step && (nxt == cmp);
    ev_o[EV_PRD]  = step && (nxt == prd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_o <= cnt_d;
      if (dir_restart) up_q <= 1'b1;
      else if (step)   up_q <= up_d;
    end
  end
endmodule

// File: rtl/gpt_flags.sv
module gpt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = (flags_o & ~(clr_wr ? clr_mask : '0)) | set_i;
    irq_o   = |(flags_o & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flags_d;
  end
endmodule

// File: rtl/gp_pwm_timer.sv
module gp_pwm_timer
  import gpt_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int PS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  input  logic              ext_clk_i,
  input  logic              dir_i,
  output logic [NUM_EV-1:0] flags_o,
  output logic              irq_o,
  output logic              pwm_o
);
  localparam int NSH = 2;

  logic [W-1:0]        ctrl_q, ctrl_d;
  logic [NUM_EV-1:0]   ien_q, ien_d;
  logic                wr_ctrl, wr_ien, wr_flg, cnt_wr, tick;
  mode_e               mode;
  logic [W-1:0]        cnt;
  logic [NUM_EV-1:0]   ev;
  logic [NSH-1:0]      sh_wr, sh_load;
  logic [NSH-1:0][W-1:0] sh_val, act_val;
  logic [W-1:0]        prd_act, cmp_act;

  always_comb begin
    wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
    wr_ien  = wr_en_i && (wr_addr_i == A_IEN);
    wr_flg  = wr_en_i && (wr_addr_i == A_IFLG);
    cnt_wr  = wr_en_i && (wr_addr_i == A_CNT);
    sh_wr[0] = wr_en_i && (wr_addr_i == A_PRD);
    sh_wr[1] = wr_en_i && (wr_addr_i == A_CMP);
    ctrl_d  = wr_ctrl ? wr_data_i : ctrl_q;
    ien_d   = wr_ien ? wr_data_i[NUM_EV-1:0] : ien_q;
    mode    = mode_e'(ctrl_q[1:0]);
    sh_load[0] = ev[EV_ZERO];
    sh_load[1] = ev[EV_ZERO] || (ctrl_q[CB_DBLUPD] && ev[EV_PRD]);
    prd_act = act_val[0];
    cmp_act = act_val[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
    end
  end

  gpt_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(mode != MODE_STOP),
    .ext_sel(ctrl_q[CB_EXT]), .ext_clk_i(ext_clk_i),
    .presc_n(ctrl_q[CB_PS_LO +: PS_W]), .restart(wr_ctrl), .tick_o(tick)
  );

  for (genvar g = 0; g < NSH; g++) begin : g_shadow
    gpt_shadow_reg #(.W(W)) u_sh (
      .clk(clk), .rst_n(rst_n), .wr_en(sh_wr[g]), .wr_data(wr_data_i),
      .load(sh_load[g]), .shadow_o(sh_val[g]), .active_o(act_val[g])
    );
  end

  gpt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .dir_i(dir_i),
    .dir_restart(wr_ctrl), .prd(prd_act), .cmp(cmp_act), .cnt_wr(cnt_wr),
    .cnt_wr_data(wr_data_i), .cnt_o(cnt), .ev_o(ev)
  );

  gpt_flags #(.N(NUM_EV)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_i(ev), .clr_wr(wr_flg),
    .clr_mask(wr_data_i[NUM_EV-1:0]), .en_i(ien_q), .flags_o(flags_o), .irq_o(irq_o)
  );

  always_comb begin
    pwm_o = (mode != MODE_STOP) && (cnt >= cmp_act);
    unique case (rd_addr_i)
      A_CTRL:   rd_data_o = ctrl_q;
      A_CNT:    rd_data_o = cnt;
      A_PRD:    rd_data_o = prd_act;
      A_CMP:    rd_data_o = cmp_act;
      A_IEN:    rd_data_o = {{(W-NUM_EV){1'b0}}, ien_q};
      A_IFLG:   rd_data_o = {{(W-NUM_EV){1'b0}}, flags_o};
      A_PRD_SH: rd_data_o = sh_val[0];
      default:  rd_data_o = sh_val[1];
    endcase
  end
endmodule

// File: rtl/gp_pwm_timer_chk.sv
module gp_pwm_timer_chk
  import gpt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [NUM_EV-1:0] flags_o,
  input logic              irq_o,
  input logic              pwm_o,
  input mode_e             mode,
  input logic              tick,
  input logic              cnt_wr,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      prd_act
);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i == A_IFLG) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o != '0));

  a_r2_period_loads_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prd_act) |-> (cnt == '0));

  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP && tick && !cnt_wr && cnt < prd_act) |=> (cnt == $past(cnt) + 1'b1));

  a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && !cnt_wr) |=> $stable(cnt));

  a_r12_pwm_low_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP) |-> !pwm_o);
endmodule

bind gp_pwm_timer gp_pwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .flags_o(flags_o), .irq_o(irq_o), .pwm_o(pwm_o), .mode(mode), .tick(tick),
  .cnt_wr(cnt_wr), .cnt(cnt), .prd_act(prd_act)
);

// File: tb/gp_pwm_timer_tb.sv
module gp_pwm_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [15:0] rd_data_o;
  logic        ext_clk_i;
  logic        dir_i;
  logic [3:0]  flags_o;
  logic        irq_o;
  logic        pwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] val;
    logic        pwm;
    logic        pwm_chk;
    string       tag;
  } item_t;
  item_t exp_q[$];

  gp_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ext_clk_i(ext_clk_i), .dir_i(dir_i), .flags_o(flags_o), .irq_o(irq_o),
    .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
    rd_addr_i = a;
    #1;
    check(tag, rd_data_o, exp);
  endtask

  task automatic push(logic [15:0] v, logic p, logic pc, string tag);
    item_t it;
    it.val = v; it.pwm = p; it.pwm_chk = pc; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: one expected item per clock, sampled after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, rd_data_o, it.val);
        if (it.pwm_chk) check({it.tag, " pwm"}, {15'd0, pwm_o}, {15'd0, it.pwm});
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    rd_addr_i = '0; ext_clk_i = 1'b0; dir_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1 reg", 3'(a), 16'h0);
    check("R1 flags", {12'd0, flags_o}, 16'h0);
    check("R1 irq", {15'd0, irq_o}, 16'h0);
    check("R1 pwm", {15'd0, pwm_o}, 16'h0);

    // R2 shadow writes
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd2);
    rd("R2 period active", 3'd2, 16'd0);
    rd("R2 period shadow", 3'd6, 16'd3);
    rd("R2 compare active", 3'd3, 16'd0);
    rd("R2 compare shadow", 3'd7, 16'd2);

    // R13 counter write, R7 stopped hold
    wr(3'd1, 16'd5);
    rd("R13 count load", 3'd1, 16'd5);
    idle(5);
    rd("R7 stopped hold", 3'd1, 16'd5);
    wr(3'd1, 16'd0);

    // R4 up mode sawtooth with R12 pwm
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0001);
    push(16'd0, 1'b0, 1'b0, "R4");
    push(16'd0, 1'b0, 1'b1, "R4 R12");
    push(16'd1, 1'b0, 1'b1, "R4 R12");
    push(16'd2, 1'b1, 1'b1, "R4 R12");
    push(16'd3, 1'b1, 1'b1, "R4 R12");
    push(16'd0, 1'b0, 1'b1, "R4 R12");
    push(16'd1, 1'b0, 1'b1, "R4 R12");
    push(16'd2, 1'b1, 1'b1, "R4 R12");
    push(16'd3, 1'b1, 1'b1, "R4 R12");
    drain();
    wr(3'd0, 16'h0000);
    check("R12 pwm stopped", {15'd0, pwm_o}, 16'h0);
    rd("R2 period after zero", 3'd2, 16'd3);
    rd("R3 compare after zero", 3'd3, 16'd2);

    // R10 flags, R11 irq
    check("R10 flags after up run", {12'd0, flags_o}, 16'h000D);
    check("R11 irq masked", {15'd0, irq_o}, 16'h0);
    wr(3'd4, 16'h0004);
    check("R11 irq enabled", {15'd0, irq_o}, 16'h1);
    wr(3'd5, 16'h0004);
    rd("R10 w1c compare", 3'd5, 16'h0009);
    check("R11 irq after clear", {15'd0, irq_o}, 16'h0);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h000F);
    check("R10 all cleared", {12'd0, flags_o}, 16'h0);

    // R8 prescaler divide by 4
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0009);
    push(16'd0, 1'b0, 1'b0, "R8");
    push(16'd0, 1'b0, 1'b0, "R8");
    push(16'd0, 1'b0, 1'b0, "R8");
    push(16'd0, 1'b0, 1'b0, "R8");
    push(16'd1, 1'b0, 1'b0, "R8");
    push(16'd1, 1'b0, 1'b0, "R8");
    push(16'd1, 1'b0, 1'b0, "R8");
    push(16'd1, 1'b0, 1'b0, "R8");
    push(16'd2, 1'b0, 1'b0, "R8");
    drain();
    wr(3'd0, 16'h0000);

    // R5 up/down triangle
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0002);
    push(16'd0, 1'b0, 1'b0, "R5");
    push(16'd1, 1'b0, 1'b0, "R5");
    push(16'd2, 1'b0, 1'b0, "R5");
    push(16'd3, 1'b0, 1'b0, "R5");
    push(16'd2, 1'b0, 1'b0, "R5");
    push(16'd1, 1'b0, 1'b0, "R5");
    push(16'd0, 1'b0, 1'b0, "R5");
    push(16'd1, 1'b0, 1'b0, "R5");
    push(16'd2, 1'b0, 1'b0, "R5");
    drain();
    wr(3'd0, 16'h0000);

    // R6 directional, down
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0003);
    push(16'd0, 1'b0, 1'b0, "R6 down");
    push(16'd3, 1'b0, 1'b0, "R6 down");
    push(16'd2, 1'b0, 1'b0, "R6 down");
    push(16'd1, 1'b0, 1'b0, "R6 down");
    push(16'd0, 1'b0, 1'b0, "R6 down");
    push(16'd3, 1'b0, 1'b0, "R6 down");
    drain();
    wr(3'd0, 16'h0000);

    // R6 directional, up
    dir_i = 1'b1;
    idle(4);
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0003);
    push(16'd0, 1'b0, 1'b0, "R6 up");
    push(16'd1, 1'b0, 1'b0, "R6 up");
    push(16'd2, 1'b0, 1'b0, "R6 up");
    push(16'd3, 1'b0, 1'b0, "R6 up");
    push(16'd0, 1'b0, 1'b0, "R6 up");
    push(16'd1, 1'b0, 1'b0, "R6 up");
    drain();
    wr(3'd0, 16'h0000);
    dir_i = 1'b0;

    // R3 double update: compare reloads at period match
    wr(3'd3, 16'd1);
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd3;
    wr(3'd0, 16'h0042);
    push(16'd2, 1'b0, 1'b0, "R3 dbl");
    push(16'd2, 1'b0, 1'b0, "R3 dbl");
    push(16'd2, 1'b0, 1'b0, "R3 dbl");
    push(16'd1, 1'b0, 1'b0, "R3 dbl");
    push(16'd1, 1'b0, 1'b0, "R3 dbl");
    drain();
    wr(3'd0, 16'h0000);

    // R3 zero-only reload
    wr(3'd3, 16'd2);
    wr(3'd1, 16'd0);
    rd_addr_i = 3'd3;
    wr(3'd0, 16'h0002);
    for (int i = 0; i < 6; i++) push(16'd1, 1'b0, 1'b0, "R3 zero");
    push(16'd2, 1'b0, 1'b0, "R3 zero");
    drain();
    wr(3'd0, 16'h0000);

    // R9 external clock source
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0021);
    idle(10);
    rd("R9 no edges", 3'd1, 16'd0);
    for (int p = 0; p < 2; p++) begin
      ext_clk_i = 1'b1; idle(4);
      ext_clk_i = 1'b0; idle(4);
    end
    idle(2);
    rd("R9 two edges", 3'd1, 16'd2);
    wr(3'd0, 16'h0000);

    // R10 overflow flag
    wr(3'd2, 16'hFFFF);
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0001);
    idle(2);
    wr(3'd0, 16'h0000);
    rd("R2 period reloaded", 3'd2, 16'hFFFF);
    check("R10 no overflow yet", {15'd0, flags_o[1]}, 16'h0);
    wr(3'd5, 16'h000F);
    wr(3'd1, 16'hFFFD);
    rd_addr_i = 3'd1;
    wr(3'd0, 16'h0001);
    push(16'hFFFD, 1'b0, 1'b0, "R10 ovf");
    push(16'hFFFE, 1'b0, 1'b0, "R10 ovf");
    push(16'hFFFF, 1'b0, 1'b0, "R10 ovf");
    push(16'h0000, 1'b0, 1'b0, "R10 ovf");
    drain();
    wr(3'd0, 16'h0000);
    check("R10 overflow flag", {15'd0, flags_o[1]}, 16'h1);
    check("R10 period flag", {15'd0, flags_o[3]}, 16'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule